// File: doc/BRIEF.md
# Dual-Width Integer Execute Unit with Byte Swap

This block is the integer execute stage of a 64-bit register machine. Each operation arrives as an 8-bit opcode, the current values of the destination and source registers, and a 32-bit immediate. The block returns a 64-bit value to be written back to the destination register, along with a flag that marks encodings it does not accept. The same operation set exists in a 32-bit form and a 64-bit form. The 32-bit form works on the low halves of the operands and zero-extends its result.

Every operation except unsigned divide and modulo finishes on the clock edge that accepts it. Divide and modulo with a nonzero divisor go to an iterative restoring divider. That divider holds `busy` high for one cycle per result bit, and a `start` seen while it is busy is dropped. The written-back value stays on `result` until the next operation completes.

Top module: `alu_exec`

## Requirements
- R1: Opcode bits [2:0] pick the width: 3'b100 is the 32-bit form and 3'b111 is the 64-bit form. Bit 3 picks the second operand: 1 selects `src_val` and 0 selects the immediate. Bits [7:4] pick the operation: 0 add, 1 sub, 2 mul, 3 div, 4 or, 5 and, 6 left shift, 7 logical right shift, 8 negate, 9 mod, 10 xor, 11 move, 12 arithmetic right shift, 13 byte order.
- R2: Add, sub, mul, or, and, xor and move wrap modulo the operand width. Every 32-bit form result has bits [63:32] equal to zero.
- R3: In the 64-bit form, the immediate is sign-extended from bit 31. In the 32-bit form, only its 32 bits are used.
- R4: The shift count is the second operand ANDed with 0x3F in the 64-bit form and with 0x1F in the 32-bit form. An arithmetic right shift fills from bit 63 in the 64-bit form and from bit 31 in the 32-bit form.
- R5: Negate returns the two's complement of `dst_val`, taken over 64 bits or over the low 32 bits, in which case it is zero-extended.
- R6: Divide and modulo are unsigned. A 64-bit immediate divisor is sign-extended first and then read as unsigned.
- R7: A zero divisor gives 0 for divide. For modulo it gives `dst_val` unchanged in the 64-bit form and the low 32 bits of `dst_val`, zero-extended, in the 32-bit form.
- R8: Byte-order operations use the 32-bit class code only (opcodes 0xd4 and 0xdc) and read only `dst_val`. The immediate gives the width: 16, 32 or 64. With bit 3 clear, the low bytes of that width are kept and zero-extended. With bit 3 set, those bytes are reversed and zero-extended.
- R9: `illegal` is 1 and `result` is 0 for any of these: a width code other than 3'b100 or 3'b111; an operation value of 14 or 15; negate with bit 3 set; a byte-order operation in the 64-bit class; or a byte-order width other than 16, 32 or 64.
- R10: For every operation except a divide or modulo with a nonzero divisor, `done` pulses for one cycle right after the edge that samples `start`. A divide or modulo with a nonzero divisor raises `busy` after that edge and raises `done` exactly 64 edges later, on the same edge where `busy` falls.
- R11: A `start` while `busy` is high is ignored: no `done` until the divider finishes, and the divider's result is unaffected.
- R12: After reset, `done`, `busy`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request, taken when `busy` is low |
| opcode | input | 8 | Operation encoding |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| busy | output | 1 | Divider iterating |
| done | output | 1 | One-cycle pulse when `result` is new |
| result | output | 64 | Value to write back |
| illegal | output | 1 | Last completed operation was not accepted |

## Verification
A divider counter or partial remainder that goes wrong does not show up while the divide is running. It appears only at the end, as `done` coming on the wrong edge or as a wrong quotient or remainder. For that reason the bench checks the exact edge of `done` and the full 64-bit value for every divide. A decode error shows up immediately at the next `done`, as a wrong `illegal` flag or as nonzero upper bits on a 32-bit result. Mixed random operations follow the directed corner cases, so that a wrong state left behind by one operation surfaces in the operation after it.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_SHL  = 4'h6,
    OP_SHR  = 4'h7,
    OP_NEG  = 4'h8,
    OP_MOD  = 4'h9,
    OP_XOR  = 4'ha,
    OP_MOV  = 4'hb,
    OP_SAR  = 4'hc,
    OP_BORD = 4'hd
  } op_e;

  localparam logic [2:0] CLS_W32 = 3'b100;
  localparam logic [2:0] CLS_W64 = 3'b111;

  typedef struct packed {
    op_e  op;
    logic w32;
    logic use_src;
    logic illegal;
  } dec_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
#(
  parameter int IMMW = 32
) (
  input  logic [7:0]      opcode,
  input  logic [IMMW-1:0] imm,
  output dec_t            dec
);

  logic [2:0] cls;
  logic       bad_cls, bad_code, bad_neg, bad_bord, width_ok;

  always_comb begin
    cls         = opcode[2:0];
    dec.op      = op_e'(opcode[7:4]);
    dec.use_src = opcode[3];
    dec.w32     = (cls == CLS_W32);
    width_ok    = (imm == IMMW'(16)) || (imm == IMMW'(32)) || (imm == IMMW'(64));
    bad_cls     = (cls != CLS_W32) && (cls != CLS_W64);
    bad_code    = (opcode[7:4] > 4'hd);
    bad_neg     = (opcode[7:4] == 4'h8) && opcode[3];
    bad_bord    = (opcode[7:4] == 4'hd) && (!dec.w32 || !width_ok);
    dec.illegal = bad_cls || bad_code || bad_neg || bad_bord;
  end

  // R9: a byte-order opcode that was accepted must be in the 32-bit class
  always_comb begin
    if (!dec.illegal && opcode[7:4] == 4'hd)
      a_bord_w32_r9: assert (opcode[2:0] == CLS_W32);
  end

endmodule

// File: rtl/alu_fastpath.sv
module alu_fastpath
  import alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 32
) (
  input  dec_t            dec,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] res
);

  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);
  localparam int NB   = XLEN / 8;

  logic [SHW-1:0]  sh_amt;
  logic [HALF-1:0] a_lo, shr_lo, sar_lo;
  logic [XLEN-1:0] full, rev_full, bord;
  logic [HALF-1:0] rev_half;
  logic [15:0]     rev_16;

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_rev_full
      assign rev_full[8*gi +: 8] = a[8*(NB-1-gi) +: 8];
    end
    for (gi = 0; gi < NB/2; gi++) begin : g_rev_half
      assign rev_half[8*gi +: 8] = a[8*(NB/2-1-gi) +: 8];
    end
    for (gi = 0; gi < 2; gi++) begin : g_rev_16
      assign rev_16[8*gi +: 8] = a[8*(1-gi) +: 8];
    end
  endgenerate

  always_comb begin
    a_lo   = a[HALF-1:0];
    sh_amt = dec.w32 ? {1'b0, b[SHW-2:0]} : b[SHW-1:0];
    shr_lo = a_lo >> sh_amt;
    sar_lo = $unsigned($signed(a_lo) >>> sh_amt);

    if (imm == IMMW'(16))
      bord = dec.use_src ? {{(XLEN-16){1'b0}}, rev_16} : {{(XLEN-16){1'b0}}, a[15:0]};
    else if (imm == IMMW'(32))
      bord = dec.use_src ? {{HALF{1'b0}}, rev_half} : {{HALF{1'b0}}, a_lo};
    else
      bord = dec.use_src ? rev_full : a;

    unique case (dec.op)
      OP_ADD:  full = a + b;
      OP_SUB:  full = a - b;
      OP_MUL:  full = a * b;
      OP_OR:   full = a | b;
      OP_AND:  full = a & b;
      OP_XOR:  full = a ^ b;
      OP_SHL:  full = a << sh_amt;
      OP_SHR:  full = dec.w32 ? {{HALF{1'b0}}, shr_lo} : (a >> sh_amt);
      OP_SAR:  full = dec.w32 ? {{HALF{1'b0}}, sar_lo} : $unsigned($signed(a) >>> sh_amt);
      OP_NEG:  full = -a;
      OP_MOV:  full = b;
      default: full = '0;
    endcase

    if (dec.op == OP_BORD)
      res = bord;
    else if (dec.w32)
      res = {{HALF{1'b0}}, full[HALF-1:0]};
    else
      res = full;
  end

endmodule

// File: rtl/alu_divider.sv
module alu_divider #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  input  logic            want_rem,
  output logic            busy,
  output logic            last_step,
  output logic [XLEN-1:0] value_nxt
);

  localparam int CW = $clog2(XLEN) + 1;

  logic            run_q, run_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [XLEN-1:0] rem_q, rem_d, quo_q, quo_d, dvs_q, dvs_d;
  logic            sel_q, sel_d;
  logic [XLEN:0]   rem_sh, diff;
  logic            ge;
  logic [XLEN-1:0] rem_step, quo_step;

  always_comb begin
    rem_sh   = {rem_q, quo_q[XLEN-1]};
    diff     = rem_sh - {1'b0, dvs_q};
    ge       = !diff[XLEN];
    rem_step = ge ? diff[XLEN-1:0] : rem_sh[XLEN-1:0];
    quo_step = {quo_q[XLEN-2:0], ge};

    run_d = run_q;
    cnt_d = cnt_q;
    rem_d = rem_q;
    quo_d = quo_q;
    dvs_d = dvs_q;
    sel_d = sel_q;
    if (load) begin
      run_d = 1'b1;
      cnt_d = CW'(XLEN);
      rem_d = '0;
      quo_d = dividend;
      dvs_d = divisor;
      sel_d = want_rem;
    end else if (run_q) begin
      rem_d = rem_step;
      quo_d = quo_step;
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      sel_q <= 1'b0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
      sel_q <= sel_d;
    end
  end

  assign busy      = run_q;
  assign last_step = run_q && (cnt_q == CW'(1));
  assign value_nxt = sel_q ? rem_step : quo_step;

  p_count_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0));

  p_rem_below_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (rem_q < dvs_q));

  p_load_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !run_q);

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      opcode,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  input  logic [IMMW-1:0] imm,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result,
  output logic            illegal
);

  localparam int HALF = XLEN / 2;

  dec_t            dec;
  logic [XLEN-1:0] opnd_b, dvd, dvs, fast_res, fast_sel;
  logic            accept, is_divmod, div_load, div_busy, div_last;
  logic [XLEN-1:0] div_val;
  logic            done_q, done_d, ill_q, ill_d;
  logic [XLEN-1:0] res_q, res_d;

  alu_decode #(.IMMW(IMMW)) u_dec (
    .opcode (opcode),
    .imm    (imm),
    .dec    (dec)
  );

  always_comb begin
    if (dec.use_src)
      opnd_b = src_val;
    else if (dec.w32)
      opnd_b = {{(XLEN-IMMW){1'b0}}, imm};
    else
      opnd_b = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
    dvd = dec.w32 ? {{HALF{1'b0}}, dst_val[HALF-1:0]} : dst_val;
    dvs = dec.w32 ? {{HALF{1'b0}}, opnd_b[HALF-1:0]}  : opnd_b;
  end

  alu_fastpath #(.XLEN(XLEN), .IMMW(IMMW)) u_fast (
    .dec (dec),
    .a   (dst_val),
    .b   (opnd_b),
    .imm (imm),
    .res (fast_res)
  );

  always_comb begin
    accept    = start && !div_busy;
    is_divmod = !dec.illegal && (dec.op == OP_DIV || dec.op == OP_MOD);
    div_load  = accept && is_divmod && (dvs != '0);
    if (dec.illegal)
      fast_sel = '0;
    else if (dec.op == OP_DIV)
      fast_sel = '0;
    else if (dec.op == OP_MOD)
      fast_sel = dvd;
    else
      fast_sel = fast_res;
  end

  alu_divider #(.XLEN(XLEN)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (div_load),
    .dividend  (dvd),
    .divisor   (dvs),
    .want_rem  (dec.op == OP_MOD),
    .busy      (div_busy),
    .last_step (div_last),
    .value_nxt (div_val)
  );

  always_comb begin
    done_d = 1'b0;
    res_d  = res_q;
    ill_d  = ill_q;
    if (div_last) begin
      done_d = 1'b1;
      res_d  = div_val;
      ill_d  = 1'b0;
    end else if (accept && !div_load) begin
      done_d = 1'b1;
      res_d  = fast_sel;
      ill_d  = dec.illegal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      res_q  <= '0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      res_q  <= res_d;
      ill_q  <= ill_d;
    end
  end

  assign busy    = div_busy;
  assign done    = done_q;
  assign result  = res_q;
  assign illegal = ill_q;

  p_illegal_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |-> (res_q == '0));

  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !done_q);

  p_busy_end_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_busy) |-> done_q);

  p_start_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && !div_last) |=> !done_q);

endmodule

// File: tb/alu_exec_tb_top.sv
module alu_exec_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  logic        clk, rst_n, start;
  logic [7:0]  opcode;
  logic [63:0] dst_val, src_val;
  logic [31:0] imm;
  logic        busy, done, illegal;
  logic [63:0] result;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  alu_exec dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .dst_val(dst_val), .src_val(src_val), .imm(imm),
    .busy(busy), .done(done), .result(result), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: returns {illegal, value}
  function automatic logic [64:0] ref_model(input logic [7:0] op, input logic [63:0] d,
                                            input logic [63:0] s, input logic [31:0] im);
    logic [2:0]  cls = op[2:0];
    logic [3:0]  code = op[7:4];
    logic        x = op[3];
    bit          w32 = (cls == 3'b100);
    logic [63:0] b, r;
    logic [31:0] d32, b32, r32;
    if (cls != 3'b100 && cls != 3'b111) return {1'b1, 64'd0};
    if (code > 4'd13) return {1'b1, 64'd0};
    b = x ? s : (w32 ? {32'd0, im} : {{32{im[31]}}, im});
    d32 = d[31:0];
    b32 = b[31:0];
    r = 64'd0; r32 = 32'd0;
    case (code)
      4'd0:  begin r = d + b;  r32 = d32 + b32; end
      4'd1:  begin r = d - b;  r32 = d32 - b32; end
      4'd2:  begin r = d * b;  r32 = d32 * b32; end
      4'd3:  begin r = (b == 0) ? 64'd0 : d / b; r32 = (b32 == 0) ? 32'd0 : d32 / b32; end
      4'd4:  begin r = d | b;  r32 = d32 | b32; end
      4'd5:  begin r = d & b;  r32 = d32 & b32; end
      4'd6:  begin r = d << b[5:0]; r32 = d32 << b32[4:0]; end
      4'd7:  begin r = d >> b[5:0]; r32 = d32 >> b32[4:0]; end
      4'd8:  begin if (x) return {1'b1, 64'd0}; r = -d; r32 = -d32; end
      4'd9:  begin r = (b == 0) ? d : d % b; r32 = (b32 == 0) ? d32 : d32 % b32; end
      4'd10: begin r = d ^ b;  r32 = d32 ^ b32; end
      4'd11: begin r = b;      r32 = b32; end
      4'd12: begin r = $unsigned($signed(d) >>> b[5:0]); r32 = $unsigned($signed(d32) >>> b32[4:0]); end
      default: begin
        if (!w32) return {1'b1, 64'd0};
        if (im == 16) return {1'b0, x ? {48'd0, d[7:0], d[15:8]} : {48'd0, d[15:0]}};
        if (im == 32) return {1'b0, x ? {32'd0, d[7:0], d[15:8], d[23:16], d[31:24]} : {32'd0, d32}};
        if (im == 64) return {1'b0, x ? {d[7:0], d[15:8], d[23:16], d[31:24],
                                          d[39:32], d[47:40], d[55:48], d[63:56]} : d};
        return {1'b1, 64'd0};
      end
    endcase
    return {1'b0, w32 ? {32'd0, r32} : r};
  endfunction

  function automatic int ref_latency(input logic [7:0] op, input logic [63:0] s, input logic [31:0] im);
    bit w32 = (op[2:0] == 3'b100);
    logic [63:0] b;
    if (op[2:0] != 3'b100 && op[2:0] != 3'b111) return 0;
    if (op[7:4] != 4'd3 && op[7:4] != 4'd9) return 0;
    b = op[3] ? s : (w32 ? {32'd0, im} : {{32{im[31]}}, im});
    if (w32) b = {32'd0, b[31:0]};
    return (b != 0) ? XLEN : 0;
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    if (op[2:0] != 3'b100 && op[2:0] != 3'b111) return "R9";
    case (op[7:4])
      4'd3, 4'd9:        return "R6";
      4'd6, 4'd7, 4'd12: return "R4";
      4'd8:              return "R5";
      4'd13:             return "R8";
      4'd14, 4'd15:      return "R9";
      default:           return "R2";
    endcase
  endfunction

  // Issue one operation; poke_at >= 0 drives a stray start while busy (R11)
  task automatic run_op(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                        input logic [31:0] im, input string tag, input int poke_at);
    logic [64:0] exp = ref_model(op, d, s, im);
    int lat = ref_latency(op, s, im);
    int n = 0;
    @(negedge clk);
    start = 1'b1; opcode = op; dst_val = d; src_val = s; imm = im;
    @(negedge clk);
    start = 1'b0;
    while (!done && n <= lat + 4) begin
      if (n == 0 && lat > 0)
        check(busy == 1'b1, "R10", "busy after divide start", {63'd0, busy}, 64'd1);
      if (n == poke_at) begin
        start = 1'b1; opcode = 8'h07; dst_val = 64'h55; src_val = 64'h0; imm = 32'h1;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    check(n == lat, (poke_at >= 0) ? "R11" : "R10", "done latency", 64'(n), 64'(lat));
    check(result == exp[63:0], tag, $sformatf("result op=%h", op), result, exp[63:0]);
    check(illegal == exp[64], tag, $sformatf("illegal op=%h", op), {63'd0, illegal}, {63'd0, exp[64]});
    @(negedge clk);
    check(done == 1'b0, "R10", "done is one pulse", {63'd0, done}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; opcode = 8'h0; dst_val = '0; src_val = '0; imm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(done == 0 && busy == 0 && illegal == 0, "R12", "reset flags",
          {61'd0, done, busy, illegal}, 64'd0);
    check(result == 64'd0, "R12", "reset result", result, 64'd0);

    // R1 / R2 width and source selection, wrap and zero extension
    run_op(8'h0f, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 32'h0, "R2", -1);
    run_op(8'h0c, 64'h1234_5678_FFFF_FFFF, 64'hAAAA_0000_0000_0003, 32'h0, "R2", -1);
    run_op(8'h1c, 64'h0, 64'h1, 32'h0, "R1", -1);
    run_op(8'h2f, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 32'h0, "R2", -1);
    run_op(8'hbc, 64'hDEAD_BEEF_0000_0000, 64'hFFFF_FFFF_8000_0001, 32'h0, "R2", -1);
    // R3 immediate extension
    run_op(8'h07, 64'h10, 64'h0, 32'h8000_0000, "R3", -1);
    run_op(8'h04, 64'h10, 64'h0, 32'h8000_0000, "R3", -1);
    run_op(8'hb7, 64'h0, 64'h0, 32'hFFFF_FFFE, "R3", -1);
    // R4 shift masking and sign fill
    run_op(8'h6f, 64'h1, 64'd65, 32'h0, "R4", -1);
    run_op(8'h6c, 64'h1, 64'd33, 32'h0, "R4", -1);
    run_op(8'hcf, 64'h8000_0000_0000_0000, 64'd4, 32'h0, "R4", -1);
    run_op(8'hcc, 64'h0000_0000_8000_0000, 64'd36, 32'h0, "R4", -1);
    run_op(8'h7c, 64'hFFFF_FFFF_FFFF_FFFF, 64'd31, 32'h0, "R4", -1);
    // R5 negate
    run_op(8'h87, 64'h5, 64'h0, 32'h0, "R5", -1);
    run_op(8'h84, 64'h0000_0001_0000_0005, 64'h0, 32'h0, "R5", -1);
    // R6 unsigned divide / modulo
    run_op(8'h3f, 64'hFFFF_FFFF_FFFF_FFF0, 64'd7, 32'h0, "R6", -1);
    run_op(8'h9f, 64'hFFFF_FFFF_FFFF_FFF0, 64'd7, 32'h0, "R6", -1);
    run_op(8'h37, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'hFFFF_FFFF, "R6", -1);
    run_op(8'h34, 64'hFFFF_FFFF_8000_0000, 64'h0, 32'hFFFF_FFFF, "R6", -1);
    run_op(8'h9c, 64'h1111_2222_0000_0064, 64'd9, 32'h0, "R6", -1);
    // R7 zero divisor
    run_op(8'h3f, 64'h1234, 64'd0, 32'h0, "R7", -1);
    run_op(8'h9f, 64'hABCD_0000_0000_1234, 64'd0, 32'h0, "R7", -1);
    run_op(8'h9c, 64'hABCD_0000_0000_1234, 64'h1_0000_0000, 32'h0, "R7", -1);
    run_op(8'h94, 64'hABCD_0000_0000_1234, 64'h0, 32'h0, "R7", -1);
    // R8 byte order
    run_op(8'hd4, 64'h0102_0304_0506_0708, 64'h0, 32'd16, "R8", -1);
    run_op(8'hd4, 64'h0102_0304_0506_0708, 64'h0, 32'd32, "R8", -1);
    run_op(8'hd4, 64'h0102_0304_0506_0708, 64'h0, 32'd64, "R8", -1);
    run_op(8'hdc, 64'h0102_0304_0506_0708, 64'hFF, 32'd16, "R8", -1);
    run_op(8'hdc, 64'h0102_0304_0506_0708, 64'h0, 32'd32, "R8", -1);
    run_op(8'hdc, 64'h0102_0304_0506_0708, 64'h0, 32'd64, "R8", -1);
    // R9 rejected encodings
    run_op(8'hd4, 64'h1, 64'h0, 32'd8, "R9", -1);
    run_op(8'hdc, 64'h1, 64'h0, 32'd0, "R9", -1);
    run_op(8'hd7, 64'h1, 64'h0, 32'd16, "R9", -1);
    run_op(8'hef, 64'h1, 64'h2, 32'h0, "R9", -1);
    run_op(8'h8f, 64'h1, 64'h2, 32'h0, "R9", -1);
    run_op(8'h0d, 64'h1, 64'h2, 32'h0, "R9", -1);
    // R11 stray start during divide
    run_op(8'h3f, 64'd1000, 64'd7, 32'h0, "R11", 5);
    run_op(8'h9c, 64'hFFFF_FFFF, 64'd10, 32'h0, "R11", 40);
    // Mixed operations across all codes and both widths
    for (int i = 0; i < 300; i++) begin
      logic [7:0]  op;
      logic [31:0] im;
      logic [63:0] s;
      op = {4'($urandom_range(0, 15)), 1'($urandom), (($urandom & 1) != 0) ? 3'b111 : 3'b100};
      s  = {$urandom, $urandom};
      if ((i % 7) == 0) s = {32'd0, 32'($urandom_range(0, 70))};
      case ($urandom_range(0, 4))
        0: im = 32'd16;
        1: im = 32'd32;
        2: im = 32'd64;
        3: im = 32'd0;
        default: im = $urandom;
      endcase
      run_op(op, {$urandom, $urandom}, s, im, tag_of(op), -1);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule